// File: doc/BRIEF.md
# Asymmetric Micro-op Dispatcher

This block sits between an instruction pre-classifier and a rename stage. Each cycle it looks at up to three instructions in program order, presented on three input lanes, and turns them into a group of up to six micro-ops. The hardware is asymmetric. Lane 0 feeds a complex decoder that expands one instruction into one to four micro-ops. Lanes 1 and 2 feed simple decoders that handle only single micro-op instructions. An instruction that expands to more than four micro-ops is sent to a sequencer. The sequencer streams that instruction's micro-ops out of an external ROM, up to six per cycle, until it reaches an entry marked as the end of the sequence.

The input handshake is partial. Each cycle `inTake` reports how many leading lanes were consumed, and the upstream shifts the rest down. An instruction that a lane cannot decode waits for lane 0, and every lane after it waits too. The micro-op group is held in a registered six-entry buffer. When rename holds `outReady` low, the buffer, the sequencer position and the input are all frozen.

Top module: `dispatch_top`

## Requirements
- R1: After reset, `outValid` is all zero. `inTake` is 0 while no input lane is valid.
- R2: A lane-0 instruction with class 1 (complex) and count field c produces c+1 micro-ops. Each micro-op word is {payload, sub} with a 2-bit sub index counting 0..c. The first micro-op carries `outFirst` and the last carries `outLast`.
- R3: A lane 1 or 2 instruction with class 0 (simple) produces one micro-op {payload, 2'b00} with both `outFirst` and `outLast` set. The micro-ops are packed in lane order after the lane-0 micro-ops, so three instructions can give up to six micro-ops in one group.
- R4: An instruction whose class is not 0 in lane 1 or 2 is not consumed, and neither is any lane after it. `inTake` equals the number of leading lanes consumed.
- R5: A lane-0 instruction with class bit 1 set (class 2 or 3) is consumed alone. Its micro-ops are the ROM words at consecutive addresses, starting at the low 8 payload bits. They are emitted up to six per group and stop after the first word whose end flag is set.
- R6: While a sequenced instruction still has micro-ops left to emit, `inTake` is 0.
- R7: Sequenced micro-ops beyond six go out in the following group or groups, in address order. `outFirst` is set only on the first micro-op of the sequence and `outLast` only on the entry whose end flag is set.
- R8: While the group is non-empty and `outReady` is low, the outputs hold their values, `inTake` is 0, and no micro-op is lost or repeated after release.
- R9: Every micro-op carries the index of its source instruction on `outIdx`.
- R10: The valid entries of a group are contiguous from entry 0. An entry marked first at position k>0 follows an entry marked last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 3 | Lane valid bits, contiguous from lane 0 |
| inClass | input | 6 | 2-bit class per lane: 0 simple, 1 complex, 2/3 sequenced |
| inCount | input | 6 | 2-bit count per lane, complex micro-ops minus one |
| inPayload | input | 42 | 14-bit payload per lane; low 8 bits are the ROM start for sequenced instructions |
| inIdx | input | 18 | 6-bit instruction index per lane |
| inTake | output | 2 | Number of leading lanes consumed this cycle |
| romAddr | output | 48 | Six 8-bit ROM read addresses |
| romWord | input | 96 | Six 16-bit ROM micro-op words |
| romEnd | input | 6 | End-of-sequence flag per ROM word |
| outValid | output | 6 | Group entry valid bits |
| outUop | output | 96 | Six 16-bit micro-op words |
| outIdx | output | 36 | Source instruction index per entry |
| outFirst | output | 6 | First micro-op of its instruction |
| outLast | output | 6 | Last micro-op of its instruction |
| outReady | input | 1 | Rename stage accepts the current group |

## Verification
The hardest case to reach from the ports is a rename stall that lands in the middle of a sequenced instruction. At that point the sequencer pointer, the group and the waiting input lanes must all freeze together, and the stream must then resume at the exact next ROM address. The bench starts an eight micro-op sequence and drops `outReady` right after the first six-entry group appears, with a simple instruction already waiting in lane 0. It holds the stall for two cycles and then checks that the two remaining words come out next, before the waiting instruction is taken. Separate scenarios put the end flag at the first entry, at the sixth entry and beyond the sixth, so that both the spill and the no-spill paths are covered.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int LANES    = 3;
  localparam int GROUP    = 6;
  localparam int MAX_CPLX = 4;
  localparam int CLS_W    = 2;
  localparam int CPLX_W   = $clog2(MAX_CPLX);
  localparam int CNT_W    = $clog2(GROUP + 1);
  localparam int TAKE_W   = $clog2(LANES + 1);

  localparam logic [CLS_W-1:0] CLS_SIMPLE  = 2'd0;
  localparam logic [CLS_W-1:0] CLS_COMPLEX = 2'd1;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic             advance;   // group register loads
    logic             seqMode;   // group filled from ROM
    logic             seqStart;  // sequence begins from lane 0 now
    logic             seqDone;   // end flag seen in this group
    logic [CNT_W-1:0] emitCnt;   // micro-ops in the new group
    logic [CNT_W-1:0] lane0Cnt;  // micro-ops from lane 0 (decoder mode)
    logic [LANES-1:0] take;      // lanes consumed (decoder mode)
  } dispStrobe_t;
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES*CLS_W-1:0]  inClass,
  input  logic [LANES*CPLX_W-1:0] inCount,
  input  logic [GROUP-1:0]        romEnd,
  input  logic                    grpBusy,
  input  logic                    outReady,
  output logic                    seqActive,
  output logic [TAKE_W-1:0]       inTake,
  output dispStrobe_t             strb
);
  logic [CLS_W-1:0] laneCls [LANES];
  logic             lane0Seq;
  logic             endFound;
  logic [CNT_W-1:0] endCnt;
  logic [CNT_W-1:0] decCnt;
  logic [TAKE_W-1:0] takeSum;

  always_comb begin
    for (int k = 0; k < LANES; k++) laneCls[k] = inClass[k*CLS_W +: CLS_W];
  end

  // first ROM word carrying the end flag
  always_comb begin
    endFound = 1'b0;
    endCnt   = CNT_W'(GROUP);
    for (int j = GROUP - 1; j >= 0; j--) begin
      if (romEnd[j]) begin
        endFound = 1'b1;
        endCnt   = CNT_W'(j + 1);
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.advance = !grpBusy || outReady;
    lane0Seq     = inValid[0] && laneCls[0][1];
    strb.seqMode = seqActive || lane0Seq;
    strb.seqStart = !seqActive && lane0Seq;
    strb.seqDone = strb.seqMode && endFound;

    // in-order steering: later lanes need simple class and a taken predecessor
    strb.take[0] = inValid[0] && !laneCls[0][1];
    for (int k = 1; k < LANES; k++)
      strb.take[k] = strb.take[k-1] && inValid[k] && (laneCls[k] == CLS_SIMPLE);

    if (!strb.take[0])                      strb.lane0Cnt = '0;
    else if (laneCls[0] == CLS_COMPLEX)     strb.lane0Cnt = CNT_W'(inCount[0 +: CPLX_W]) + CNT_W'(1);
    else                                    strb.lane0Cnt = CNT_W'(1);

    decCnt  = strb.lane0Cnt;
    takeSum = '0;
    for (int k = 0; k < LANES; k++) begin
      takeSum = takeSum + TAKE_W'(strb.take[k]);
      if (k > 0) decCnt = decCnt + CNT_W'(strb.take[k]);
    end
    strb.emitCnt = strb.seqMode ? endCnt : decCnt;

    if (!strb.advance || seqActive) inTake = '0;
    else if (lane0Seq)              inTake = TAKE_W'(1);
    else                            inTake = takeSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              seqActive <= 1'b0;
    else if (strb.advance && strb.seqMode)  seqActive <= !endFound;
  end
endmodule

// File: rtl/dispatch_dpath.sv
module dispatch_dpath
  import dispatch_pkg::*;
#(
  parameter int PAY_W  = 14,
  parameter int IDX_W  = 6,
  parameter int ROM_AW = 8,
  localparam int UOP_W = PAY_W + CPLX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dispStrobe_t             strb,
  input  logic                    seqActive,
  input  logic [LANES*PAY_W-1:0]  inPayload,
  input  logic [LANES*IDX_W-1:0]  inIdx,
  input  logic [GROUP*UOP_W-1:0]  romWord,
  output logic [GROUP*ROM_AW-1:0] romAddr,
  output logic                    grpBusy,
  output logic [GROUP-1:0]        outValid,
  output logic [GROUP*UOP_W-1:0]  outUop,
  output logic [GROUP*IDX_W-1:0]  outIdx,
  output logic [GROUP-1:0]        outFirst,
  output logic [GROUP-1:0]        outLast
);
  logic [ROM_AW-1:0] seqPtr, seqBase;
  logic [IDX_W-1:0]  seqIdx;
  logic [PAY_W-1:0]  lanePay [LANES];
  logic [IDX_W-1:0]  laneIdx [LANES];

  logic [GROUP-1:0]  grpValid, nValid, nFirst, nLast, grpFirst, grpLast;
  logic [UOP_W-1:0]  grpUop [GROUP];
  logic [UOP_W-1:0]  nUop   [GROUP];
  logic [IDX_W-1:0]  grpIdx [GROUP];
  logic [IDX_W-1:0]  nIdx   [GROUP];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lanePay[k] = inPayload[k*PAY_W +: PAY_W];
      laneIdx[k] = inIdx[k*IDX_W +: IDX_W];
    end
  end

  assign seqBase = seqActive ? seqPtr : lanePay[0][ROM_AW-1:0];

  genvar g;
  generate
    for (g = 0; g < GROUP; g++) begin : gEntry
      assign romAddr[g*ROM_AW +: ROM_AW] = seqBase + ROM_AW'(g);
      assign outUop[g*UOP_W +: UOP_W]    = grpUop[g];
      assign outIdx[g*IDX_W +: IDX_W]    = grpIdx[g];
    end
  endgenerate

  // next-group builder
  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      nValid[j] = 1'b0;
      nUop[j]   = '0;
      nIdx[j]   = laneIdx[0];
      nFirst[j] = 1'b0;
      nLast[j]  = 1'b0;
      if (strb.seqMode) begin
        if (CNT_W'(j) < strb.emitCnt) begin
          nValid[j] = 1'b1;
          nUop[j]   = romWord[j*UOP_W +: UOP_W];
          nIdx[j]   = seqActive ? seqIdx : laneIdx[0];
          nFirst[j] = strb.seqStart && (j == 0);
          nLast[j]  = strb.seqDone && (CNT_W'(j + 1) == strb.emitCnt);
        end
      end else begin
        if (CNT_W'(j) < strb.lane0Cnt) begin
          nValid[j] = 1'b1;
          nUop[j]   = {lanePay[0], CPLX_W'(j)};
          nFirst[j] = (j == 0);
          nLast[j]  = (CNT_W'(j + 1) == strb.lane0Cnt);
        end
        for (int k = 1; k < LANES; k++) begin
          if (strb.take[k] && (CNT_W'(j) == strb.lane0Cnt + CNT_W'(k - 1))) begin
            nValid[j] = 1'b1;
            nUop[j]   = {lanePay[k], {CPLX_W{1'b0}}};
            nIdx[j]   = laneIdx[k];
            nFirst[j] = 1'b1;
            nLast[j]  = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpValid <= '0;
      grpFirst <= '0;
      grpLast  <= '0;
      seqPtr   <= '0;
      seqIdx   <= '0;
      for (int j = 0; j < GROUP; j++) begin
        grpUop[j] <= '0;
        grpIdx[j] <= '0;
      end
    end else if (strb.advance) begin
      grpValid <= nValid;
      grpFirst <= nFirst;
      grpLast  <= nLast;
      for (int j = 0; j < GROUP; j++) begin
        grpUop[j] <= nUop[j];
        grpIdx[j] <= nIdx[j];
      end
      if (strb.seqMode)  seqPtr <= seqBase + ROM_AW'(GROUP);
      if (strb.seqStart) seqIdx <= laneIdx[0];
    end
  end

  assign grpBusy  = |grpValid;
  assign outValid = grpValid;
  assign outFirst = grpFirst;
  assign outLast  = grpLast;
endmodule

// File: rtl/dispatch_top.sv
module dispatch_top
  import dispatch_pkg::*;
#(
  parameter int PAY_W  = 14,
  parameter int IDX_W  = 6,
  parameter int ROM_AW = 8,
  localparam int UOP_W = PAY_W + CPLX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES*CLS_W-1:0]  inClass,
  input  logic [LANES*CPLX_W-1:0] inCount,
  input  logic [LANES*PAY_W-1:0]  inPayload,
  input  logic [LANES*IDX_W-1:0]  inIdx,
  output logic [TAKE_W-1:0]       inTake,
  output logic [GROUP*ROM_AW-1:0] romAddr,
  input  logic [GROUP*UOP_W-1:0]  romWord,
  input  logic [GROUP-1:0]        romEnd,
  output logic [GROUP-1:0]        outValid,
  output logic [GROUP*UOP_W-1:0]  outUop,
  output logic [GROUP*IDX_W-1:0]  outIdx,
  output logic [GROUP-1:0]        outFirst,
  output logic [GROUP-1:0]        outLast,
  input  logic                    outReady
);
  dispStrobe_t strb;
  logic        seqActive;
  logic        grpBusy;

  dispatch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .inCount(inCount), .romEnd(romEnd), .grpBusy(grpBusy),
    .outReady(outReady), .seqActive(seqActive), .inTake(inTake), .strb(strb)
  );

  dispatch_dpath #(.PAY_W(PAY_W), .IDX_W(IDX_W), .ROM_AW(ROM_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .seqActive(seqActive),
    .inPayload(inPayload), .inIdx(inIdx), .romWord(romWord),
    .romAddr(romAddr), .grpBusy(grpBusy), .outValid(outValid),
    .outUop(outUop), .outIdx(outIdx), .outFirst(outFirst), .outLast(outLast)
  );
endmodule

// File: rtl/dispatch_chk.sv
module dispatch_chk
  import dispatch_pkg::*;
#(
  parameter int UOP_W = 16,
  parameter int IDX_W = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [LANES-1:0]       inValid,
  input logic [LANES*CLS_W-1:0] inClass,
  input logic [TAKE_W-1:0]      inTake,
  input logic [GROUP-1:0]       outValid,
  input logic [GROUP*UOP_W-1:0] outUop,
  input logic [GROUP*IDX_W-1:0] outIdx,
  input logic [GROUP-1:0]       outFirst,
  input logic [GROUP-1:0]       outLast,
  input logic                   outReady
);
  AST_GROUP_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid & GROUP'(outValid + GROUP'(1))) == '0);  // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid && !outReady) |=> ($stable(outValid) && $stable(outUop) && $stable(outIdx)));  // R8

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid && !outReady) |-> (inTake == '0));  // R8

  AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    inTake <= TAKE_W'($countones(inValid)));  // R4

  AST_SEQ_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid[0] && inClass[1]) |-> (inTake <= TAKE_W'(1)));  // R5

  genvar g;
  generate
    for (g = 1; g < GROUP; g++) begin : gOrder
      AST_FIRST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[g] && outFirst[g]) |-> outLast[g-1]);  // R10
    end
  endgenerate
endmodule

bind dispatch_top dispatch_chk #(.UOP_W(UOP_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
  .inTake(inTake), .outValid(outValid), .outUop(outUop), .outIdx(outIdx),
  .outFirst(outFirst), .outLast(outLast), .outReady(outReady)
);

// File: tb/tb_dispatch_top.sv
module tb_dispatch_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  inValid = '0;
  logic [5:0]  inClass = '0;
  logic [5:0]  inCount = '0;
  logic [41:0] inPayload = '0;
  logic [17:0] inIdx = '0;
  logic [1:0]  inTake;
  logic [47:0] romAddr;
  logic [95:0] romWord;
  logic [5:0]  romEnd;
  logic [5:0]  outValid;
  logic [95:0] outUop;
  logic [35:0] outIdx;
  logic [5:0]  outFirst, outLast;
  logic        outReady = 1'b1;
  logic [255:0] endMark = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dispatch_top dut (.*);

  function automatic logic [15:0] romVal(input logic [7:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  always_comb begin
    for (int j = 0; j < 6; j++) begin
      romWord[j*16 +: 16] = romVal(romAddr[j*8 +: 8]);
      romEnd[j]           = endMark[romAddr[j*8 +: 8]];
    end
  end

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setLane(input int k, input logic [1:0] cls, input logic [1:0] cnt,
                         input logic [13:0] pay, input logic [5:0] idx);
    inValid[k]            = 1'b1;
    inClass[k*2 +: 2]     = cls;
    inCount[k*2 +: 2]     = cnt;
    inPayload[k*14 +: 14] = pay;
    inIdx[k*6 +: 6]       = idx;
  endtask

  task automatic clearLanes();
    inValid = '0;
    inClass = '0;
    inCount = '0;
    inPayload = '0;
    inIdx = '0;
  endtask

  task automatic expectCount(input string req, input int n);
    checkEq(req, "outValid", int'(outValid), (1 << n) - 1);
  endtask

  task automatic expectUop(input string req, input int j, input logic [15:0] word,
                           input logic [5:0] idx, input logic first, input logic last);
    checkEq(req, $sformatf("entry%0d", j),
            int'({outValid[j], outUop[j*16 +: 16], outIdx[j*6 +: 6], outFirst[j], outLast[j]}),
            int'({1'b1, word, idx, first, last}));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic testReset();
    #1;
    checkEq("R1", "outValid after reset", int'(outValid), 0);
    checkEq("R1", "inTake idle", int'(inTake), 0);
  endtask

  task automatic testFullGroup();
    setLane(0, 2'd1, 2'd3, 14'h111, 6'd1);
    setLane(1, 2'd0, 2'd0, 14'h222, 6'd2);
    setLane(2, 2'd0, 2'd0, 14'h333, 6'd3);
    #1 checkEq("R3", "inTake three lanes", int'(inTake), 3);
    tick();
    clearLanes();
    expectCount("R3", 6);
    for (int j = 0; j < 4; j++)
      expectUop("R2", j, {14'h111, 2'(j)}, 6'd1, j == 0, j == 3);
    expectUop("R3", 4, {14'h222, 2'b00}, 6'd2, 1'b1, 1'b1);
    expectUop("R9", 5, {14'h333, 2'b00}, 6'd3, 1'b1, 1'b1);
    tick();
    expectCount("R3", 0);
  endtask

  task automatic testSteer();
    setLane(0, 2'd0, 2'd0, 14'h010, 6'd4);
    setLane(1, 2'd1, 2'd1, 14'h020, 6'd5);
    setLane(2, 2'd0, 2'd0, 14'h030, 6'd6);
    #1 checkEq("R4", "complex in lane1 stalls", int'(inTake), 1);
    tick();
    expectCount("R4", 1);
    expectUop("R4", 0, {14'h010, 2'b00}, 6'd4, 1'b1, 1'b1);
    clearLanes();
    setLane(0, 2'd1, 2'd1, 14'h020, 6'd5);
    setLane(1, 2'd0, 2'd0, 14'h030, 6'd6);
    #1 checkEq("R4", "re-steered to lane0", int'(inTake), 2);
    tick();
    expectCount("R2", 3);
    expectUop("R2", 0, {14'h020, 2'd0}, 6'd5, 1'b1, 1'b0);
    expectUop("R2", 1, {14'h020, 2'd1}, 6'd5, 1'b0, 1'b1);
    expectUop("R4", 2, {14'h030, 2'd0}, 6'd6, 1'b1, 1'b1);
    clearLanes();
    setLane(0, 2'd0, 2'd0, 14'h040, 6'd7);
    setLane(1, 2'd2, 2'd0, 14'h050, 6'd8);
    setLane(2, 2'd0, 2'd0, 14'h060, 6'd9);
    #1 checkEq("R4", "sequenced in lane1 stalls", int'(inTake), 1);
    tick();
    clearLanes();
    expectCount("R4", 1);
    tick();
  endtask

  task automatic testSeqSpill();
    endMark[8'h28] = 1'b1;
    setLane(0, 2'd2, 2'd0, 14'h020, 6'd10);
    setLane(1, 2'd0, 2'd0, 14'h0AA, 6'd11);
    #1 checkEq("R5", "sequenced taken alone", int'(inTake), 1);
    tick();
    clearLanes();
    setLane(0, 2'd0, 2'd0, 14'h0AA, 6'd11);
    expectCount("R5", 6);
    for (int j = 0; j < 6; j++)
      expectUop("R5", j, romVal(8'(8'h20 + j)), 6'd10, j == 0, 1'b0);
    #1 checkEq("R6", "no take while streaming", int'(inTake), 0);
    tick();
    expectCount("R7", 3);
    for (int j = 0; j < 3; j++)
      expectUop("R7", j, romVal(8'(8'h26 + j)), 6'd10, 1'b0, j == 2);
    #1 checkEq("R6", "take after sequence end", int'(inTake), 1);
    tick();
    clearLanes();
    expectCount("R3", 1);
    expectUop("R9", 0, {14'h0AA, 2'b00}, 6'd11, 1'b1, 1'b1);
    tick();
  endtask

  task automatic testSeqEdges();
    endMark[8'h65] = 1'b1;
    setLane(0, 2'd3, 2'd0, 14'h060, 6'd12);
    #1 checkEq("R5", "six-entry sequence taken", int'(inTake), 1);
    tick();
    clearLanes();
    setLane(0, 2'd0, 2'd0, 14'h0BB, 6'd13);
    expectCount("R7", 6);
    expectUop("R7", 0, romVal(8'h60), 6'd12, 1'b1, 1'b0);
    expectUop("R7", 5, romVal(8'h65), 6'd12, 1'b0, 1'b1);
    #1 checkEq("R6", "no spill, take at once", int'(inTake), 1);
    tick();
    clearLanes();
    endMark[8'h70] = 1'b1;
    setLane(0, 2'd2, 2'd0, 14'h070, 6'd14);
    #1;
    tick();
    clearLanes();
    expectCount("R5", 1);
    expectUop("R5", 0, romVal(8'h70), 6'd14, 1'b1, 1'b1);
    tick();
  endtask

  task automatic testBackpressure();
    endMark[8'h47] = 1'b1;
    setLane(0, 2'd2, 2'd0, 14'h040, 6'd20);
    #1;
    tick();
    clearLanes();
    setLane(0, 2'd0, 2'd0, 14'h0CC, 6'd21);
    outReady = 1'b0;
    #1 checkEq("R8", "no take under stall", int'(inTake), 0);
    tick();
    expectCount("R8", 6);
    expectUop("R8", 0, romVal(8'h40), 6'd20, 1'b1, 1'b0);
    tick();
    expectUop("R8", 5, romVal(8'h45), 6'd20, 1'b0, 1'b0);
    outReady = 1'b1;
    #1;
    tick();
    expectCount("R8", 2);
    expectUop("R8", 0, romVal(8'h46), 6'd20, 1'b0, 1'b0);
    expectUop("R8", 1, romVal(8'h47), 6'd20, 1'b0, 1'b1);
    #1 checkEq("R8", "take after release", int'(inTake), 1);
    tick();
    clearLanes();
    expectUop("R8", 0, {14'h0CC, 2'b00}, 6'd21, 1'b1, 1'b1);
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testFullGroup();
    testSteer();
    testSeqSpill();
    testSeqEdges();
    testBackpressure();
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end
endmodule